// File: doc/BRIEF.md
# Accumulator Logic and Rotate Unit

This block is the execute stage for a small slice of an 8-bit accumulator machine. It holds the accumulator and the zero flag. On every clock it applies one decoded operation, taken from a short list. The operations are: do nothing; OR the accumulator with a memory byte or with an immediate byte into the accumulator; OR the accumulator with a memory byte back into memory; and rotate a memory byte left by one bit as a closed ring.

The decoder in front of the block supplies the operation code, the byte read from memory and the immediate byte. The result is registered on the rising edge, and the block presents four outputs: the new accumulator, the new zero flag, and a one-cycle memory write strobe with its data. Where the result goes depends on the operation, and so does its effect on the flag. The rotate uses no carry and never touches the flag.

Top module: `acc_logic_rot_unit`

## Requirements
- R1: With `rst` high at a rising edge, the accumulator, the zero flag and the write strobe are all 0 after that edge, whatever the operation inputs are.
- R2: Code 1 (OR with memory) loads the accumulator with the accumulator OR `mem_rdata`, ignores `imm`, and leaves the write strobe low.
- R3: Code 2 (OR with immediate) loads the accumulator with the accumulator OR `imm`, ignores `mem_rdata`, and leaves the write strobe low.
- R4: Code 3 (OR to memory) drives the write strobe high for the following cycle with write data equal to the accumulator OR `mem_rdata`, and leaves the accumulator unchanged.
- R5: Codes 1, 2 and 3 set the zero flag to 1 when their 8-bit OR result is 0x00, and clear it to 0 otherwise.
- R6: Code 4 (rotate left) drives the write strobe high with data {mem_rdata[6:0], mem_rdata[7]}, and leaves both the accumulator and the zero flag unchanged, even when the result is 0x00.
- R7: Code 0 (no operation) leaves the accumulator and the zero flag unchanged and keeps the write strobe low. The unused codes 5, 6 and 7 behave the same way.
- R8: The write strobe is high in a cycle only when the operation at the preceding edge was code 3 or code 4. A single write operation gives a strobe exactly one cycle long.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| op_sel | input | 3 | Decoded operation code (0 nop, 1 OR mem, 2 OR imm, 3 OR to mem, 4 rotate left) |
| mem_rdata | input | 8 | Byte read from the addressed memory location |
| imm | input | 8 | Immediate byte |
| acc_o | output | 8 | Registered accumulator |
| zero_o | output | 1 | Registered zero flag |
| mem_we_o | output | 1 | Memory write strobe, one cycle per write operation |
| mem_wdata_o | output | 8 | Memory write data, valid while the strobe is high |

## Verification
The bench rotates bytes that have bit 7 set. A design that shifts without wrapping would drop that bit, and one that rotates right would move the wrong end. It rotates zero while the flag is clear, and a non-zero byte while the flag is set. A design that lets the rotate touch the flag would fail both cases. It runs OR-to-memory with a zero result and checks that the accumulator keeps its value, so that a wrong destination or missing flag update shows up. It feeds the no-operation and unused codes with all-ones operands, and it follows each write with a non-write operation. This catches a strobe that sticks high and an accumulator that takes a value it should ignore.

// File: rtl/acc_pkg.sv
package acc_pkg;

    localparam int DATA_W = 8;
    localparam int OP_W   = 3;

    typedef enum logic [OP_W-1:0] {
        OP_NOP    = 3'd0,
        OP_OR_MEM = 3'd1,
        OP_OR_IMM = 3'd2,
        OP_OR_TOM = 3'd3,
        OP_ROTL   = 3'd4
    } op_e;

    typedef struct packed {
        logic [DATA_W-1:0] acc;
        logic              zero;
        logic              we;
        logic [DATA_W-1:0] wdata;
    } exec_state_t;

endpackage

// File: rtl/alu_or_unit.sv
module alu_or_unit #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] y_o
);

    for (genvar g = 0; g < W; g++) begin : g_bit
        assign y_o[g] = a_i[g] | b_i[g];
    end

endmodule

// File: rtl/alu_rotl_unit.sv
module alu_rotl_unit #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    output logic [W-1:0] y_o
);

    assign y_o[0] = a_i[W-1];
    for (genvar g = 1; g < W; g++) begin : g_bit
        assign y_o[g] = a_i[g-1];
    end

endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    output logic         zero_o
);

    assign zero_o = ~|a_i;

endmodule

// File: rtl/acc_logic_rot_unit.sv
module acc_logic_rot_unit
    import acc_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] op_sel,
    input  logic [W-1:0]    mem_rdata,
    input  logic [W-1:0]    imm,
    output logic [W-1:0]    acc_o,
    output logic            zero_o,
    output logic            mem_we_o,
    output logic [W-1:0]    mem_wdata_o
);

    logic [W-1:0] acc_q, acc_d;
    logic         zero_q, zero_d;
    logic         we_q, we_d;
    logic [W-1:0] wdata_q, wdata_d;

    logic [W-1:0] or_b;
    logic [W-1:0] or_res;
    logic [W-1:0] rot_res;
    logic         or_zero;

    assign or_b = (op_sel == OP_OR_IMM) ? imm : mem_rdata;

    alu_or_unit #(.W(W)) or_i (
        .a_i (acc_q),
        .b_i (or_b),
        .y_o (or_res)
    );

    alu_rotl_unit #(.W(W)) rotl_i (
        .a_i (mem_rdata),
        .y_o (rot_res)
    );

    alu_zero_detect #(.W(W)) zdet_i (
        .a_i    (or_res),
        .zero_o (or_zero)
    );

    always_comb begin
        acc_d   = acc_q;
        zero_d  = zero_q;
        we_d    = 1'b0;
        wdata_d = wdata_q;
        unique case (op_sel)
            OP_OR_MEM, OP_OR_IMM: begin
                acc_d  = or_res;
                zero_d = or_zero;
            end
            OP_OR_TOM: begin
                zero_d  = or_zero;
                we_d    = 1'b1;
                wdata_d = or_res;
            end
            OP_ROTL: begin
                we_d    = 1'b1;
                wdata_d = rot_res;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            zero_q  <= 1'b0;
            we_q    <= 1'b0;
            wdata_q <= '0;
        end else begin
            acc_q   <= acc_d;
            zero_q  <= zero_d;
            we_q    <= we_d;
            wdata_q <= wdata_d;
        end
    end

    assign acc_o       = acc_q;
    assign zero_o      = zero_q;
    assign mem_we_o    = we_q;
    assign mem_wdata_o = wdata_q;

    assert_nop_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_NOP || op_sel > OP_ROTL) |=> ($stable(acc_o) && $stable(zero_o) && !mem_we_o));

    assert_orm_acc_R4: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_OR_TOM) |=> ($stable(acc_o) && mem_we_o
            && mem_wdata_o == ($past(acc_o) | $past(mem_rdata))));

    assert_rotl_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_ROTL) |=> ($stable(zero_o) && $stable(acc_o) && mem_we_o));

    assert_or_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (op_sel == OP_OR_MEM || op_sel == OP_OR_IMM) |=> (zero_o == (acc_o == '0)));

    assert_we_source_R8: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |-> ($past(op_sel) == OP_OR_TOM || $past(op_sel) == OP_ROTL));

endmodule

// File: tb/acc_logic_rot_unit_tb_top.sv
module acc_logic_rot_unit_tb_top;

    localparam int CLK_P = 10;
    localparam int NV    = 10;

    typedef struct packed {
        logic [2:0] op;
        logic [7:0] mem;
        logic [7:0] imm;
        logic [7:0] e_acc;
        logic       e_z;
        logic       e_we;
        logic [7:0] e_wd;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{3'd2, 8'hFF, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00},
        '{3'd1, 8'h00, 8'hFF, 8'h00, 1'b1, 1'b0, 8'h00},
        '{3'd2, 8'h00, 8'h5A, 8'h5A, 1'b0, 1'b0, 8'h00},
        '{3'd0, 8'hFF, 8'hFF, 8'h5A, 1'b0, 1'b0, 8'h00},
        '{3'd3, 8'h81, 8'h00, 8'h5A, 1'b0, 1'b1, 8'hDB},
        '{3'd4, 8'h81, 8'h00, 8'h5A, 1'b0, 1'b1, 8'h03},
        '{3'd1, 8'h24, 8'hFF, 8'h7E, 1'b0, 1'b0, 8'h00},
        '{3'd4, 8'h80, 8'h00, 8'h7E, 1'b0, 1'b1, 8'h01},
        '{3'd4, 8'h00, 8'h00, 8'h7E, 1'b0, 1'b1, 8'h00},
        '{3'd5, 8'hFF, 8'hFF, 8'h7E, 1'b0, 1'b0, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] op_sel;
    logic [7:0] mem_rdata, imm;
    logic [7:0] acc_o, mem_wdata_o;
    logic       zero_o, mem_we_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    acc_logic_rot_unit dut_i (
        .clk         (clk),
        .rst         (rst),
        .op_sel      (op_sel),
        .mem_rdata   (mem_rdata),
        .imm         (imm),
        .acc_o       (acc_o),
        .zero_o      (zero_o),
        .mem_we_o    (mem_we_o),
        .mem_wdata_o (mem_wdata_o)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [2:0] o, input logic [7:0] m, input logic [7:0] i);
        op_sel = o; mem_rdata = m; imm = i;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 5000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; op_sel = 3'd2; mem_rdata = 8'hFF; imm = 8'hFF;
        @(negedge clk);
        @(negedge clk);
        chk("R1 acc", acc_o, 8'h00);
        chk("R1 zero", {7'b0, zero_o}, 8'h00);
        chk("R1 we", {7'b0, mem_we_o}, 8'h00);
        rst = 1'b0;

        // Table walk covers R2 R3 R4 R5 R6 R7 R8
        for (int k = 0; k < NV; k++) begin
            step(VECS[k].op, VECS[k].mem, VECS[k].imm);
            chk($sformatf("R2/R3 acc v%0d", k), acc_o, VECS[k].e_acc);
            chk($sformatf("R5 zero v%0d", k), {7'b0, zero_o}, {7'b0, VECS[k].e_z});
            chk($sformatf("R8 we v%0d", k), {7'b0, mem_we_o}, {7'b0, VECS[k].e_we});
            if (VECS[k].e_we)
                chk($sformatf("R4/R6 wdata v%0d", k), mem_wdata_o, VECS[k].e_wd);
        end

        // R7: unused code 7 with all-ones operands
        step(3'd7, 8'hFF, 8'hFF);
        chk("R7 acc code7", acc_o, 8'h7E);
        chk("R7 we code7", {7'b0, mem_we_o}, 8'h00);

        // R1: reset during a write operation
        rst = 1'b1;
        step(3'd3, 8'hFF, 8'hFF);
        chk("R1 acc mid", acc_o, 8'h00);
        chk("R1 we mid", {7'b0, mem_we_o}, 8'h00);
        rst = 1'b0;

        step(3'd2, 8'hFF, 8'h00);
        chk("R5 zero set", {7'b0, zero_o}, 8'h01);
        // R6: nonzero rotate keeps set flag
        step(3'd4, 8'h01, 8'h00);
        chk("R6 wdata", mem_wdata_o, 8'h02);
        chk("R6 zero kept", {7'b0, zero_o}, 8'h01);
        // R4/R5: OR to memory with zero result
        step(3'd3, 8'h00, 8'hFF);
        chk("R4 wdata zero", mem_wdata_o, 8'h00);
        chk("R5 zero orm", {7'b0, zero_o}, 8'h01);
        chk("R4 acc kept", acc_o, 8'h00);
        step(3'd3, 8'h10, 8'h00);
        chk("R4 wdata", mem_wdata_o, 8'h10);
        chk("R5 zero clr orm", {7'b0, zero_o}, 8'h00);
        chk("R4 acc still", acc_o, 8'h00);
        // R8: strobe drops after a non-write op
        step(3'd0, 8'hFF, 8'hFF);
        chk("R8 we drop", {7'b0, mem_we_o}, 8'h00);
        chk("R7 zero nop", {7'b0, zero_o}, 8'h00);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule